// File: doc/BRIEF.md
# Core Clock Source Switch Sequencer

This block steps a processor core from its running PLL onto a crystal reference, reprograms the PLL while nothing depends on it, and then moves the core back. The clocks are not in this block. It drives the select lines of the two clock multiplexers, the PLL setting, the core post-divider value and its write strobe, and a clock gate. It watches a PLL lock input and a divider busy input. One start request runs the whole change. The order of the steps is fixed: park the step mux on the reference, move the switch mux onto the step clock, load the PLL, wait for lock, switch back, gate the core clock, write the divider, wait for the divider to go idle, ungate.

Both waits share a programmable cycle limit. When a wait runs past the limit, the sequencer stops in an error state. It leaves the multiplexers as they are, so a core parked on the reference stays there. A new start request from that state runs the sequence again. The core divider field is three bits wide. A stored value n means divide by n+1, so divide-by-2 is written as 1.

Top module: `clk_switch_seq`

## Requirements
- R1: During and after synchronous active-low reset, every select, gate, strobe and flag output is 0. `pll_cfg_o` holds `PLL_RST` and `div_o` holds `DIV_RST`. Both default to 0.
- R2: A start accepted on clock edge c sets `step_sel_o` (1 = reference) at edge c+1. `sw_sel_o` (1 = step clock) rises one edge later, at c+2, and only while `step_sel_o` is already 1.
- R3: At edge c+3 the latched setting appears on `pll_cfg_o` and `pll_ld_o` pulses for exactly one cycle. This happens only while both selects are 1.
- R4: `sw_sel_o` returns to 0 only on an edge where `pll_lock_i` is sampled 1 in the lock wait. The first lock-wait sample is at edge c+4, so with lock first seen at c+4+k the switch back happens at c+4+k.
- R5: If lock is not seen by the wait sample that equals the limit (the sample at c+4+limit), `err_o` rises on that edge. `sw_sel_o` stays 1 and no done pulse follows. The same limit applies to the busy wait, and expiry there also raises `err_o`. Lock seen on the limit sample still counts as success.
- R6: `core_gate_o` (1 = gated) rises one edge after the switch back. On the next edge `div_o` takes the latched value and `div_wr_o` pulses for one cycle. The write happens only while the gate is set.
- R7: The busy wait begins one edge after the write. On the first edge where `div_busy_i` is sampled 0, `core_gate_o` falls and `done_o` pulses for exactly one cycle.
- R8: `busy_o` is 1 from the edge after the start is accepted until the edge that pulses done or enters the error state.
- R9: A start request while `busy_o` is 1 is ignored. The outputs and the timing of the running sequence are unchanged.
- R10: `div_o` is a 3-bit code in which n selects divide by n+1. The code is passed through unchanged (1 for divide-by-2, 7 for divide-by-8).
- R11: A start in the error state clears `err_o` on the next edge and reruns the sequence with the same step timing as from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a clock change |
| pll_cfg_i | input | PLL_W | Target PLL setting, latched at start |
| div_i | input | DIV_W | Target core divider code, latched at start |
| tmo_i | input | TMO_W | Wait limit in cycles, latched at start |
| pll_lock_i | input | 1 | PLL lock indication |
| div_busy_i | input | 1 | Divider busy handshake from the divider |
| step_sel_o | output | 1 | Step mux select, 1 = reference oscillator |
| sw_sel_o | output | 1 | Switch mux select, 1 = step clock, 0 = main PLL |
| pll_cfg_o | output | PLL_W | PLL setting applied |
| pll_ld_o | output | 1 | One-cycle strobe loading the PLL setting |
| core_gate_o | output | 1 | Core clock gate, 1 = gated off |
| div_o | output | DIV_W | Core divider code applied |
| div_wr_o | output | 1 | One-cycle divider write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Wait limit expired; held until the next start |

## Verification
A wrong state register shows up at the ports within a cycle or two. Each state has a distinct visible action on one select, strobe or gate, and each action lands on an edge whose number is fixed relative to the accepted start. A skipped or repeated step therefore moves or removes one expected event. A bad wait counter shifts the switch back, the error edge or the done pulse by whole cycles. The bench checks every event against its exact expected cycle, so a one-cycle slip is reported on the edge where it happens.

// File: rtl/clk_seq_pkg.sv
// Shared types for the core clock switch sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package clk_seq_pkg;

    // Sequencer states; each non-wait state performs one visible action on exit
    typedef enum logic [3:0] {
        SQ_IDLE  = 4'd0,
        SQ_PARK  = 4'd1,
        SQ_LOAD  = 4'd2,
        SQ_WLOCK = 4'd3,
        SQ_GATE  = 4'd4,
        SQ_DIVWR = 4'd5,
        SQ_WBUSY = 4'd6,
        SQ_ERR   = 4'd7
    } seq_state_t;

endpackage

// File: rtl/clk_seq_timer.sv
// Wait-limit counter. Counts cycles while run_i is high and clears otherwise.
// expired_o flags the cycle in which the count equals the limit.
// Assumes limit_i is constant while run_i is high.
module clk_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    // Count wait cycles; restart from zero whenever no wait is active
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;
        else            cnt_q <= '0;
    end

    assign expired_o = run_i && (cnt_q == limit_i);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= limit_i)); // R5

endmodule

// File: rtl/clk_seq_fsm.sv
// State machine of the clock switch sequence. It exposes the current and the
// next state so that the top can act on transitions.
// Assumes lock and busy inputs are synchronous to clk.
module clk_seq_fsm
    import clk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       lock_i,
    input  logic       busy_i,
    input  logic       expired_i,
    output seq_state_t state_o,
    output seq_state_t nxt_o
);

    seq_state_t state_q;
    seq_state_t nxt;

    // Next-state choice: fixed step order, two bounded waits
    always_comb begin
        nxt = state_q;
        case (state_q)
            SQ_IDLE:  if (start_i) nxt = SQ_PARK;
            SQ_PARK:  nxt = SQ_LOAD;
            SQ_LOAD:  nxt = SQ_WLOCK;
            SQ_WLOCK: if (lock_i) nxt = SQ_GATE;
                      else if (expired_i) nxt = SQ_ERR;
            SQ_GATE:  nxt = SQ_DIVWR;
            SQ_DIVWR: nxt = SQ_WBUSY;
            SQ_WBUSY: if (!busy_i) nxt = SQ_IDLE;
                      else if (expired_i) nxt = SQ_ERR;
            SQ_ERR:   if (start_i) nxt = SQ_PARK;
            default:  nxt = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= nxt;
    end

    assign state_o = state_q;
    assign nxt_o   = nxt;

    AST_START_ONLY_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_PARK) |-> ($past(state_q) == SQ_IDLE || $past(state_q) == SQ_ERR)); // R9

endmodule

// File: rtl/clk_switch_seq.sv
// Core clock source switch sequencer, top level.
// Drives the mux selects, PLL load, clock gate and divider write in the fixed
// order: park on reference, load PLL, await lock, switch back, gate, write
// divider, await divider idle, ungate. Clocks are outside this block.
// Assumes pll_lock_i and div_busy_i are synchronous to clk.
module clk_switch_seq
    import clk_seq_pkg::*;
#(
    parameter int               PLL_W   = 8,
    parameter int               DIV_W   = 3,
    parameter int               TMO_W   = 8,
    parameter logic [PLL_W-1:0] PLL_RST = '0,
    parameter logic [DIV_W-1:0] DIV_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PLL_W-1:0] pll_cfg_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             pll_lock_i,
    input  logic             div_busy_i,
    output logic             step_sel_o,
    output logic             sw_sel_o,
    output logic [PLL_W-1:0] pll_cfg_o,
    output logic             pll_ld_o,
    output logic             core_gate_o,
    output logic [DIV_W-1:0] div_o,
    output logic             div_wr_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    seq_state_t       state;
    seq_state_t       nxt;
    logic             expired;
    logic             waiting;
    logic [PLL_W-1:0] cfg_l;
    logic [DIV_W-1:0] div_l;
    logic [TMO_W-1:0] lim_l;

    assign waiting = (state == SQ_WLOCK) || (state == SQ_WBUSY);

    clk_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .lock_i    (pll_lock_i),
        .busy_i    (div_busy_i),
        .expired_i (expired),
        .state_o   (state),
        .nxt_o     (nxt)
    );

    clk_seq_timer #(.CW(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (waiting),
        .limit_i   (lim_l),
        .expired_o (expired)
    );

    // Output registers: each state's action is applied as it is left
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_sel_o  <= 1'b0;
            sw_sel_o    <= 1'b0;
            pll_cfg_o   <= PLL_RST;
            pll_ld_o    <= 1'b0;
            core_gate_o <= 1'b0;
            div_o       <= DIV_RST;
            div_wr_o    <= 1'b0;
            done_o      <= 1'b0;
            cfg_l       <= PLL_RST;
            div_l       <= DIV_RST;
            lim_l       <= '0;
        end else begin
            pll_ld_o <= 1'b0;
            div_wr_o <= 1'b0;
            done_o   <= 1'b0;
            case (state)
                SQ_IDLE, SQ_ERR: if (nxt == SQ_PARK) begin
                    step_sel_o <= 1'b1;
                    cfg_l      <= pll_cfg_i;
                    div_l      <= div_i;
                    lim_l      <= tmo_i;
                end
                SQ_PARK:  sw_sel_o <= 1'b1;
                SQ_LOAD: begin
                    pll_cfg_o <= cfg_l;
                    pll_ld_o  <= 1'b1;
                end
                SQ_WLOCK: if (nxt == SQ_GATE) sw_sel_o <= 1'b0;
                SQ_GATE:  core_gate_o <= 1'b1;
                SQ_DIVWR: begin
                    div_o    <= div_l;
                    div_wr_o <= 1'b1;
                end
                SQ_WBUSY: if (nxt == SQ_IDLE) begin
                    core_gate_o <= 1'b0;
                    done_o      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state != SQ_IDLE) && (state != SQ_ERR);
    assign err_o  = (state == SQ_ERR);

    AST_SW_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_sel_o) |-> (step_sel_o && $past(step_sel_o))); // R2
    AST_LOAD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ld_o |-> (sw_sel_o && step_sel_o)); // R3
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ld_o |=> !pll_ld_o); // R3
    AST_BACK_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_sel_o) |-> $past(pll_lock_i)); // R4
    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_o |-> (core_gate_o && $past(core_gate_o))); // R6
    AST_UNGATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_gate_o) |-> !$past(div_busy_i)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o); // R5

endmodule

// File: tb/clk_switch_seq_bench.sv
`timescale 1ns/1ps
module clk_switch_seq_bench;
    localparam int PW = 8;
    localparam int DW = 3;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [PW-1:0] pll_cfg_i = '0;
    logic [DW-1:0] div_i = '0;
    logic [TW-1:0] tmo_i = '0;
    logic          pll_lock_i = 1'b1;
    logic          div_busy_i = 1'b0;
    logic          step_sel_o, sw_sel_o, pll_ld_o, core_gate_o, div_wr_o;
    logic          busy_o, done_o, err_o;
    logic [PW-1:0] pll_cfg_o;
    logic [DW-1:0] div_o;

    clk_switch_seq u_clk_switch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_cfg_i(pll_cfg_i),
        .div_i(div_i), .tmo_i(tmo_i), .pll_lock_i(pll_lock_i),
        .div_busy_i(div_busy_i), .step_sel_o(step_sel_o), .sw_sel_o(sw_sel_o),
        .pll_cfg_o(pll_cfg_o), .pll_ld_o(pll_ld_o), .core_gate_o(core_gate_o),
        .div_o(div_o), .div_wr_o(div_wr_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    bit  mon_en = 0;

    typedef struct { int kind; int at; int val; } ev_t;
    ev_t exq[$];

    function automatic string tag_of(input int kind);
        case (kind)
            1, 2: return "R2";
            3: return "R3";
            4: return "R4";
            5, 6: return "R6";
            7: return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // PLL stand-in: lock drops on load and returns after lock_lat cycles
    int lock_lat = 1;
    int lcnt = 0;
    always @(negedge clk) begin
        if (pll_ld_o) begin
            pll_lock_i = 1'b0;
            lcnt = lock_lat;
        end else if (!pll_lock_i) begin
            if (lcnt <= 1) pll_lock_i = 1'b1;
            else lcnt--;
        end
    end

    // Divider stand-in: busy rises on write and clears after busy_lat cycles
    int busy_lat = 1;
    int bcnt = 0;
    always @(negedge clk) begin
        if (div_wr_o) begin
            div_busy_i = 1'b1;
            bcnt = busy_lat;
        end else if (div_busy_i) begin
            if (bcnt <= 1) div_busy_i = 1'b0;
            else bcnt--;
        end
    end

    task automatic observe(input int kind, input int val);
        ev_t e;
        total++;
        if (exq.size() == 0) begin
            bad++;
            $display("FAIL %s actual=event%0d@%0d expected=none", tag_of(kind), kind, cyc);
            return;
        end
        e = exq.pop_front();
        if (e.kind != kind || e.at != cyc || (e.val >= 0 && e.val != val)) begin
            bad++;
            $display("FAIL %s actual=event%0d@%0d val %0d expected=event%0d@%0d val %0d",
                     tag_of(e.kind), kind, cyc, val, e.kind, e.at, e.val);
        end
    endtask

    // Monitor: turn output edges into events and compare with the queue
    logic p_step, p_sw, p_ld, p_gate, p_wr, p_done, p_err;
    always @(negedge clk) begin
        if (mon_en) begin
            if (step_sel_o && !p_step) observe(1, -1);
            if (sw_sel_o && !p_sw)     observe(2, -1);
            if (pll_ld_o && !p_ld)     observe(3, int'(pll_cfg_o));
            if (!sw_sel_o && p_sw)     observe(4, -1);
            if (core_gate_o && !p_gate) observe(5, -1);
            if (div_wr_o && !p_wr)     observe(6, int'(div_o));
            if (done_o && !p_done) begin
                observe(7, -1);
                check("R7 gate off at done", int'(core_gate_o), 0);
            end
            if (done_o && p_done) check("R7 done width", 1, 0);
            if (err_o && !p_err)       observe(8, -1);
        end
        p_step = step_sel_o; p_sw = sw_sel_o; p_ld = pll_ld_o; p_gate = core_gate_o;
        p_wr = div_wr_o; p_done = done_o; p_err = err_o;
    end

    function automatic void push(input int kind, input int at, input int val);
        ev_t e;
        e.kind = kind; e.at = at; e.val = val;
        exq.push_back(e);
    endfunction

    // Driver: start one sequence and queue every expected output event
    task automatic run_seq(input int cfg, input int dv, input int l, input int b,
                           input int t, input bit skip_st, input bit skip_pk,
                           input bit skip_gt, input bit err_lock, input bit err_busy,
                           input bit extra_start);
        int c;
        @(negedge clk);
        lock_lat = l; busy_lat = b;
        pll_cfg_i = cfg[PW-1:0]; div_i = dv[DW-1:0]; tmo_i = t[TW-1:0];
        start_i = 1'b1;
        c = cyc;
        if (!skip_st) push(1, c + 1, -1);
        if (!skip_pk) push(2, c + 2, -1);
        push(3, c + 3, cfg);
        if (err_lock) push(8, c + 4 + t, -1);
        else begin
            push(4, c + 4 + l, -1);
            if (!skip_gt) push(5, c + 5 + l, -1);
            push(6, c + 6 + l, dv);
            if (err_busy) push(8, c + 7 + l + t, -1);
            else push(7, c + 7 + l + b, -1);
        end
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy after start", int'(busy_o), 1);
        check("R11 err cleared by start", int'(err_o), 0);
        if (extra_start) begin
            repeat (3) @(negedge clk);
            check("R9 busy at extra start", int'(busy_o), 1);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 400 && exq.size() > 0; i++) @(negedge clk);
        check("R2 all events seen", exq.size(), 0);
        exq.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 step_sel", int'(step_sel_o), 0);
        check("R1 sw_sel", int'(sw_sel_o), 0);
        check("R1 gate", int'(core_gate_o), 0);
        check("R1 flags", int'({busy_o, done_o, err_o, pll_ld_o, div_wr_o}), 0);
        check("R1 pll_cfg", int'(pll_cfg_o), 0);
        check("R1 div", int'(div_o), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(busy_o), 0);

        // Nominal change: setting 88, divide-by-2 (code 1), R10
        run_seq(88, 1, 5, 3, 20, 0, 0, 0, 0, 0, 0);
        check("R10 div code divide-by-2", int'(div_o), 1);
        check("R8 busy low after done", int'(busy_o), 0);
        check("R4 back on PLL", int'(sw_sel_o), 0);

        // Lock seen exactly on the limit sample still succeeds (R4/R5 boundary)
        run_seq(44, 7, 6, 1, 6, 1, 0, 0, 0, 0, 0);
        check("R10 div code divide-by-8", int'(div_o), 7);

        // Start during a sequence is ignored (R9)
        run_seq(120, 0, 5, 2, 20, 1, 0, 0, 0, 0, 1);
        check("R9 div after ignored start", int'(div_o), 0);

        // Lock never arrives in time (R5)
        run_seq(200, 3, 10, 1, 4, 1, 0, 0, 1, 0, 0);
        check("R5 err held", int'(err_o), 1);
        check("R5 stays on step clock", int'(sw_sel_o), 1);
        check("R5 not busy in error", int'(busy_o), 0);
        repeat (10) @(negedge clk);
        check("R5 err still held", int'(err_o), 1);

        // Rerun from error, selects already parked (R11)
        run_seq(66, 2, 2, 2, 8, 1, 1, 0, 0, 0, 0);
        check("R11 err clear after rerun", int'(err_o), 0);
        check("R11 pll applied", int'(pll_cfg_o), 66);

        // Divider busy outlasts the limit (R5), then rerun (R11)
        run_seq(77, 5, 1, 9, 3, 1, 0, 0, 0, 1, 0);
        check("R5 err after busy timeout", int'(err_o), 1);
        check("R6 gate held in error", int'(core_gate_o), 1);
        repeat (10) @(negedge clk);
        run_seq(99, 4, 1, 1, 8, 1, 0, 1, 0, 0, 0);
        check("R11 recovered div", int'(div_o), 4);
        check("R11 gate released", int'(core_gate_o), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule